// File: doc/BRIEF.md
# Flash Unlock-Sequence Command Decoder

This block sits on the host side of a word-wide NOR flash and turns the stream of bus write cycles into operation requests. Every operation is guarded by a keyed prefix: two fixed address/data writes, followed by a command byte and, for some commands, more writes. The decoder follows these sequences one write at a time. When one is complete it raises a one-clock request that carries an operation code, the target address and the data word, for the array and timing logic elsewhere in the device.

It also holds the identification mode flag. While that flag is set, a read mux returns the manufacturer code, the device code or the boot lockout status, chosen by the bus address. Any other write pattern, a read cycle inside a sequence, or the device reporting busy keeps stray bus traffic from ever becoming a command.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write is counted only when `ce_n`=0, `we_n`=0 and `oe_n`=1 are sampled together, and a strobe held for several clocks counts once. A strobe pattern with `ce_n`=1 is ignored and does not disturb a partial sequence.
- R2: Only `addr[14:0]` and `wdata[7:0]` take part in key matching. Higher address bits and the upper data byte do not affect decoding.
- R3: The writes 0xAA@0x5555, 0x55@0x2AAA and 0xA0@0x5555, followed by any fourth write, issue op 1 (program). The request carries that fourth write's full address and 16-bit data.
- R4: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555 and 0x55@0x2AAA, followed by a sixth write, issue one of three ops. 0x10@0x5555 gives op 2 (chip erase). 0x30 at any address gives op 3 (sector erase) with that address. 0x40@0x5555 gives op 4 (lockout set).
- R5: The writes 0xAA@0x5555, 0x55@0x2AAA and 0x90@0x5555 issue op 5 and set `id_mode`.
- R6: While `id_mode`=1, `id_rdata` depends on `addr[14:0]`. At 0 it is the manufacturer code parameter (default 0x00DA). At 1 it is the device code parameter (default 0x00AE). At 2 it is {15'b0, `lock_status`}. At any other address it is 0. While `id_mode`=0 it is always 0.
- R7: `id_mode` is cleared with op 6 by either of two exits. One is the prefix 0xAA@0x5555, 0x55@0x2AAA followed by 0xF0@0x5555. The other is a single 0xF0 write at any address while in ID mode with no sequence open. A lone 0xF0 outside ID mode issues nothing.
- R8: A read cycle (`ce_n`=0, `oe_n`=0) in the middle of a sequence abandons it, and the writes that follow must start a new prefix.
- R9: A write whose address or data does not match the expected step ends the sequence without a request.
- R10: Writes made while `busy`=1 issue nothing and leave the sequence state unchanged.
- R11: `rst_n`=0 clears `cmd_valid` and `id_mode` and abandons any sequence in progress.
- R12: `cmd_valid` is a single-clock pulse. It goes high on the clock edge that samples the completing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Bus chip enable, active low |
| oe_n | input | 1 | Bus output enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| addr | input | AW | Bus address |
| wdata | input | DW | Bus write data |
| busy | input | 1 | Device operation in progress |
| lock_status | input | 1 | Current boot lockout state |
| cmd_valid | output | 1 | Request pulse |
| cmd_op | output | 3 | Op code: 1 program, 2 chip erase, 3 sector erase, 4 lockout set, 5 ID entry, 6 ID exit |
| cmd_addr | output | AW | Target address of the request |
| cmd_data | output | DW | Data word of the request |
| id_mode | output | 1 | Identification mode flag |
| id_rdata | output | DW | Identification read data |

## Verification
Several rules are checked by assertions on every cycle. A request lasts one clock and follows a qualified write. Nothing is issued on the cycle after a read or while busy. The ID flag changes only together with its entry or exit request. Whether each full sequence decodes to the right op, address and data can only be shown by the bench scenarios. The same holds for the two exits, the abort and mismatch paths, the frozen state under busy, and the ID read mux values.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW = 17,
  parameter int DW = 16,
  parameter int KW = 15,
  parameter logic [DW-1:0] MFR_ID = 16'h00DA,
  parameter logic [DW-1:0] DEV_ID = 16'h00AE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  input  logic          lock_status,
  output logic          cmd_valid,
  output logic [2:0]    cmd_op,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          id_mode,
  output logic [DW-1:0] id_rdata
);
  localparam logic [KW-1:0] K_LO = KW'(15'h5555);
  localparam logic [KW-1:0] K_HI = KW'(15'h2AAA);
  localparam logic [2:0] OP_PROG = 3'd1, OP_CHIP = 3'd2, OP_SECT = 3'd3,
                         OP_LOCK = 3'd4, OP_IDIN = 3'd5, OP_IDOUT = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_K1, S_K2, S_PGM, S_E1, S_E2, S_E3} st_t;
  st_t st, nst;

  logic wr_q, fire;
  logic [2:0] nop;

  wire wr_act = !ce_n && !we_n && oe_n;
  wire rd_act = !ce_n && !oe_n;
  wire wr_evt = wr_act && !wr_q;
  wire [KW-1:0] key = addr[KW-1:0];
  wire [7:0] code = wdata[7:0];
  wire at_lo = (key == K_LO);
  wire at_hi = (key == K_HI);

  always_comb begin
    nst  = S_IDLE;
    fire = 1'b0;
    nop  = 3'd0;
    case (st)
      S_IDLE: if (at_lo && code == 8'hAA) nst = S_K1;
              else if (id_mode && code == 8'hF0) begin fire = 1'b1; nop = OP_IDOUT; end
      S_K1:   if (at_hi && code == 8'h55) nst = S_K2;
      S_K2:   if (at_lo) begin
                case (code)
                  8'hA0: nst = S_PGM;
                  8'h80: nst = S_E1;
                  8'h90: begin fire = 1'b1; nop = OP_IDIN; end
                  8'hF0: begin fire = 1'b1; nop = OP_IDOUT; end
                  default: ;
                endcase
              end
      S_PGM:  begin fire = 1'b1; nop = OP_PROG; end
      S_E1:   if (at_lo && code == 8'hAA) nst = S_E2;
      S_E2:   if (at_hi && code == 8'h55) nst = S_E3;
      S_E3:   if (code == 8'h30) begin fire = 1'b1; nop = OP_SECT; end
              else if (at_lo && code == 8'h10) begin fire = 1'b1; nop = OP_CHIP; end
              else if (at_lo && code == 8'h40) begin fire = 1'b1; nop = OP_LOCK; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      wr_q      <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_op    <= 3'd0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      id_mode   <= 1'b0;
    end else begin
      wr_q      <= wr_act;
      cmd_valid <= 1'b0;
      if (!busy) begin
        if (wr_evt) begin
          st <= nst;
          if (fire) begin
            cmd_valid <= 1'b1;
            cmd_op    <= nop;
            cmd_addr  <= addr;
            cmd_data  <= wdata;
            if (nop == OP_IDIN)  id_mode <= 1'b1;
            if (nop == OP_IDOUT) id_mode <= 1'b0;
          end
        end else if (rd_act) begin
          st <= S_IDLE;
        end
      end
    end
  end

  always_comb begin
    id_rdata = '0;
    if (id_mode) begin
      if (key == KW'(0))      id_rdata = MFR_ID;
      else if (key == KW'(1)) id_rdata = DEV_ID;
      else if (key == KW'(2)) id_rdata = DW'(lock_status);
    end
  end
endmodule

module flash_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       busy,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       id_mode
);
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r1_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(!ce_n && !we_n && oe_n));
  a_r10_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(busy));
  a_r8_read_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n) |=> !cmd_valid);
  a_r5_id_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> (cmd_valid && cmd_op == 3'd5));
  a_r7_id_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> (cmd_valid && cmd_op == 3'd6));
  a_r4_op_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op >= 3'd1 && cmd_op <= 3'd6));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .busy(busy), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .id_mode(id_mode)
);

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
  localparam int AW = 17;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0, lock_status = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic cmd_valid, id_mode;
  logic [2:0] cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data, id_rdata;

  int checks = 0, errors = 0;
  logic [35:0] expq[$];
  string tagq[$];

  always #10 clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .busy(busy), .lock_status(lock_status),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .id_mode(id_mode), .id_rdata(id_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_cmd(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    expq.push_back({op, a, d});
    tagq.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R9 unexpected request", {cmd_op, cmd_addr, cmd_data}, '0);
      end else begin
        logic [35:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk({cmd_op, cmd_addr, cmd_data} == e, t, {cmd_op, cmd_addr, cmd_data}, e);
      end
    end
  end

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int hold = 1);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (i == 1) chk(cmd_valid == 1'b0, "R12 pulse width", 36'(cmd_valid), 36'd0);
    end
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    #1 chk(id_rdata == exp, tag, 36'(id_rdata), 36'(exp));
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic prefix();
    bus_write(17'h05555, 16'h00AA);
    bus_write(17'h02AAA, 16'h0055);
  endtask

  task automatic erase_prefix();
    prefix();
    bus_write(17'h05555, 16'h0080);
    prefix();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_valid == 0 && id_mode == 0, "R11 reset state", {cmd_valid, id_mode}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    expect_cmd(3'd1, 17'h1ABCD, 16'h1234, "R3 program");
    prefix(); bus_write(17'h05555, 16'h00A0); bus_write(17'h1ABCD, 16'h1234);

    expect_cmd(3'd1, 17'h00042, 16'hBEEF, "R2 upper bits ignored");
    bus_write(17'h1D555, 16'h77AA); bus_write(17'h0AAAA, 16'hC355);
    bus_write(17'h15555, 16'h12A0); bus_write(17'h00042, 16'hBEEF);

    expect_cmd(3'd2, 17'h05555, 16'h0010, "R4 chip erase");
    erase_prefix(); bus_write(17'h05555, 16'h0010);
    expect_cmd(3'd3, 17'h05123, 16'h0030, "R4 sector erase");
    erase_prefix(); bus_write(17'h05123, 16'h0030);
    expect_cmd(3'd4, 17'h05555, 16'h0040, "R4 lockout set");
    erase_prefix(); bus_write(17'h05555, 16'h0040);

    expect_cmd(3'd5, 17'h05555, 16'h0090, "R5 id entry");
    prefix(); bus_write(17'h05555, 16'h0090);
    chk(id_mode == 1, "R5 id_mode set", 36'(id_mode), 36'd1);
    bus_read(17'h00000, 16'h00DA, "R6 manufacturer code");
    bus_read(17'h00001, 16'h00AE, "R6 device code");
    lock_status = 1'b1;
    bus_read(17'h00002, 16'h0001, "R6 lock status 1");
    lock_status = 1'b0;
    bus_read(17'h00002, 16'h0000, "R6 lock status 0");
    bus_read(17'h00003, 16'h0000, "R6 other address");

    expect_cmd(3'd6, 17'h00777, 16'h00F0, "R7 single exit");
    bus_write(17'h00777, 16'h00F0);
    chk(id_mode == 0, "R7 id_mode cleared", 36'(id_mode), 36'd0);
    bus_read(17'h00000, 16'h0000, "R6 out of id mode");

    expect_cmd(3'd5, 17'h05555, 16'h0090, "R5 id entry again");
    prefix(); bus_write(17'h05555, 16'h0090);
    expect_cmd(3'd6, 17'h05555, 16'h00F0, "R7 three-cycle exit");
    prefix(); bus_write(17'h05555, 16'h00F0);
    chk(id_mode == 0, "R7 id_mode cleared by long exit", 36'(id_mode), 36'd0);
    bus_write(17'h00123, 16'h00F0);

    prefix(); bus_read(17'h00005, 16'h0000, "R8 read in sequence");
    bus_write(17'h05555, 16'h00A0); bus_write(17'h00100, 16'h0000);
    expect_cmd(3'd1, 17'h00200, 16'h5A5A, "R8 fresh sequence after abort");
    prefix(); bus_write(17'h05555, 16'h00A0); bus_write(17'h00200, 16'h5A5A);

    bus_write(17'h05555, 16'h00AA); bus_write(17'h02AAA, 16'h0056);
    bus_write(17'h05555, 16'h00A0); bus_write(17'h00300, 16'h0001);
    bus_write(17'h05554, 16'h00AA); bus_write(17'h02AAA, 16'h0055);
    bus_write(17'h05555, 16'h0090);
    chk(id_mode == 0, "R9 mismatch no id entry", 36'(id_mode), 36'd0);
    erase_prefix(); bus_write(17'h05555, 16'h0020);

    busy = 1'b1;
    prefix(); bus_write(17'h05555, 16'h00A0); bus_write(17'h00400, 16'h1111);
    busy = 1'b0;
    expect_cmd(3'd1, 17'h00500, 16'h2222, "R10 state frozen while busy");
    prefix();
    busy = 1'b1; bus_write(17'h05555, 16'h00A0); busy = 1'b0;
    bus_write(17'h05555, 16'h00A0); bus_write(17'h00500, 16'h2222);

    expect_cmd(3'd1, 17'h00600, 16'h3333, "R1 ce_n high ignored");
    prefix();
    @(negedge clk); ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b1; addr = 17'h05555; wdata = 16'h0011;
    @(negedge clk); we_n = 1'b1;
    bus_write(17'h05555, 16'h00A0); bus_write(17'h00600, 16'h3333);

    expect_cmd(3'd1, 17'h00700, 16'h4444, "R12 held strobe counts once");
    prefix(); bus_write(17'h05555, 16'h00A0); bus_write(17'h00700, 16'h4444, 3);

    prefix(); bus_write(17'h05555, 16'h00A0);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    bus_write(17'h00800, 16'h5555);
    expect_cmd(3'd5, 17'h05555, 16'h0090, "R11 id entry before reset");
    prefix(); bus_write(17'h05555, 16'h0090);
    rst_n = 1'b0; @(negedge clk);
    chk(id_mode == 0 && cmd_valid == 0, "R11 reset clears id_mode", {cmd_valid, id_mode}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk(expq.size() == 0, "R3 all expected requests seen", 36'(expq.size()), 36'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule